// File: doc/BRIEF.md
# Paging MMU Control Plane

This block is the control side of a small two-level paging MMU. Software reaches it through a simple register port. Through that port it loads the base address of the top-level translation table. It also issues one-shot mode commands and sees fault and bus-error events. It acknowledges those events through a write-one-to-clear register. The table walker and the bus master sit outside this block. The block only holds the mode state and tells the translation cache when to drop entries.

Changes to the paging and stall modes do not take effect at once. Each one completes a fixed number of cycles after the command. This stands for the drain of outstanding traffic, and software polls the status register until the change shows. A forced reset is seen from outside when the table base register reads back as zero. The expected bring-up order is:

1. Stall.
2. Force reset.
3. Load the base.
4. Flush the cache.
5. Unmask interrupts.
6. Enable paging.
7. Leave stall.

Top module: `mmu_ctl`

## Requirements
- R1: After reset, every readable register reads zero, and `paging_on`, `stall_on`, `irq` and both flush outputs are low.
- R2: A write to offset 0x00 stores bits 31:12 of the table base. A read of 0x00 returns those bits with bits 11:0 reading as zero.
- R3: Writes to offset 0x08 carry a command in bits 3:0:
  - 0: enable paging.
  - 1: disable paging.
  - 2: enter stall.
  - 3: leave stall.
  - 4: flush the whole cache.
  - 5: page fault done.
  - 6: force reset.

  Codes 7 to 15 change no state and raise no output.
- R4: The paging and stall states each take their new value exactly 4 clock edges after the command write is sampled. The status register at 0x04 shows paging in bit 0, stall in bit 1 and a held fault in bit 2.
- R5: A force reset clears four things at the next edge: the table base, the paging state, the raw interrupt status and the held fault. The stall state is left unchanged.
- R6: A flush command raises `flush_all` for exactly the one cycle after the write.
- R7: A write to offset 0x10 raises `flush_line` for one cycle. During that cycle `flush_page` carries bits 31:12 of the written data.
- R8: A `fault_valid` pulse while paging is on and no fault is held does three things: it latches `fault_addr` into the register at 0x0C, sets raw status bit 0 and marks the fault held. Faults are ignored while paging is off or while a fault is held. Command 5 releases the hold.
- R9: A `bus_err` pulse sets raw status bit 1 (offset 0x14) in any mode.
- R10: Writing ones to offset 0x18 clears the matching raw status bits. A new event in the same cycle wins over the clear.
- R11: The mask register sits at offset 0x1C, bits 1:0. `irq` is high exactly when some raw status bit and its mask bit are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Register read data, combinational |
| fault_valid | input | 1 | Translation fault event from the walker |
| fault_addr | input | 32 | Virtual address of the fault |
| bus_err | input | 1 | Bus error event |
| irq | output | 1 | Masked interrupt request |
| paging_on | output | 1 | Live paging-enabled state |
| stall_on | output | 1 | Live stall-active state |
| flush_all | output | 1 | One-cycle whole-cache invalidate |
| flush_line | output | 1 | One-cycle single-page invalidate |
| flush_page | output | 20 | Page number for `flush_line` |

## Verification
The bench probes the mode latency at every edge from the command to the change. A design that applies the change one cycle early or late fails at the edge where it diverges. It also sends a second fault while one is held. A design that does not hold the first address loses it. It drives a clear and a bus error in the same cycle, which catches a design that gives the clear priority. It checks that a force reset leaves stall set, because a design that drops stall would break the bring-up order. Unknown command codes are followed by reads of all mode state and the flush outputs.

// File: rtl/mmu_ctl.sv
module mmu_ctl #(
  parameter int DATA_W     = 32,
  parameter int OFF_W      = 8,
  parameter int PAGE_SHIFT = 12,
  parameter int MODE_DELAY = 4,
  parameter int CODE_W     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [OFF_W-1:0]             wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [OFF_W-1:0]             rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  input  logic                         fault_valid,
  input  logic [DATA_W-1:0]            fault_addr,
  input  logic                         bus_err,
  output logic                         irq,
  output logic                         paging_on,
  output logic                         stall_on,
  output logic                         flush_all,
  output logic                         flush_line,
  output logic [DATA_W-PAGE_SHIFT-1:0] flush_page
);
  localparam int PN_W  = DATA_W - PAGE_SHIFT;
  localparam int CNT_W = $clog2(MODE_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MODE_DELAY);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  localparam logic [OFF_W-1:0] OFF_BASE = OFF_W'(8'h00);
  localparam logic [OFF_W-1:0] OFF_STAT = OFF_W'(8'h04);
  localparam logic [OFF_W-1:0] OFF_CMD  = OFF_W'(8'h08);
  localparam logic [OFF_W-1:0] OFF_FADR = OFF_W'(8'h0C);
  localparam logic [OFF_W-1:0] OFF_LINE = OFF_W'(8'h10);
  localparam logic [OFF_W-1:0] OFF_RAW  = OFF_W'(8'h14);
  localparam logic [OFF_W-1:0] OFF_CLR  = OFF_W'(8'h18);
  localparam logic [OFF_W-1:0] OFF_MASK = OFF_W'(8'h1C);

  localparam logic [CODE_W-1:0] C_PG_ON  = CODE_W'(0);
  localparam logic [CODE_W-1:0] C_PG_OFF = CODE_W'(1);
  localparam logic [CODE_W-1:0] C_ST_ON  = CODE_W'(2);
  localparam logic [CODE_W-1:0] C_ST_OFF = CODE_W'(3);
  localparam logic [CODE_W-1:0] C_FLUSH  = CODE_W'(4);
  localparam logic [CODE_W-1:0] C_DONE   = CODE_W'(5);
  localparam logic [CODE_W-1:0] C_RESET  = CODE_W'(6);

  logic [PN_W-1:0]   base_q;
  logic              pg_q, pg_tgt, st_q, st_tgt, held_q;
  logic [CNT_W-1:0]  pg_cnt, st_cnt;
  logic [DATA_W-1:0] fadr_q;
  logic [1:0]        raw_q, mask_q;

  wire              cmd_wr = wr_en && (wr_addr == OFF_CMD);
  wire [CODE_W-1:0] code   = wr_data[CODE_W-1:0];
  wire cmd_pg_on  = cmd_wr && code == C_PG_ON;
  wire cmd_pg_off = cmd_wr && code == C_PG_OFF;
  wire cmd_st_on  = cmd_wr && code == C_ST_ON;
  wire cmd_st_off = cmd_wr && code == C_ST_OFF;
  wire cmd_flush  = cmd_wr && code == C_FLUSH;
  wire cmd_done   = cmd_wr && code == C_DONE;
  wire cmd_rst    = cmd_wr && code == C_RESET;
  wire line_wr    = wr_en && (wr_addr == OFF_LINE);
  wire fault_take = fault_valid && pg_q && !held_q;
  wire [1:0] clr_bits = (wr_en && wr_addr == OFF_CLR) ? wr_data[1:0] : 2'b00;

  assign paging_on = pg_q;
  assign stall_on  = st_q;
  assign irq       = |(raw_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_q <= 1'b0; pg_tgt <= 1'b0; pg_cnt <= '0;
    end else if (cmd_rst) begin
      pg_q <= 1'b0; pg_tgt <= 1'b0; pg_cnt <= '0;
    end else if (cmd_pg_on || cmd_pg_off) begin
      pg_tgt <= cmd_pg_on;
      pg_cnt <= CNT_LOAD;
    end else if (pg_cnt != '0) begin
      pg_cnt <= pg_cnt - CNT_ONE;
      if (pg_cnt == CNT_ONE) pg_q <= pg_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= 1'b0; st_tgt <= 1'b0; st_cnt <= '0;
    end else if (cmd_st_on || cmd_st_off) begin
      st_tgt <= cmd_st_on;
      st_cnt <= CNT_LOAD;
    end else if (st_cnt != '0) begin
      st_cnt <= st_cnt - CNT_ONE;
      if (st_cnt == CNT_ONE) st_q <= st_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0; held_q <= 1'b0; fadr_q <= '0; raw_q <= '0; mask_q <= '0;
    end else begin
      if (cmd_rst) base_q <= '0;
      else if (wr_en && wr_addr == OFF_BASE) base_q <= wr_data[DATA_W-1:PAGE_SHIFT];
      if (wr_en && wr_addr == OFF_MASK) mask_q <= wr_data[1:0];
      if (cmd_rst) begin
        held_q <= 1'b0;
        fadr_q <= '0;
        raw_q  <= '0;
      end else begin
        if (fault_take) begin
          held_q <= 1'b1;
          fadr_q <= fault_addr;
        end else if (cmd_done) begin
          held_q <= 1'b0;
        end
        raw_q <= (raw_q & ~clr_bits) | {bus_err, fault_take};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_all <= 1'b0; flush_line <= 1'b0; flush_page <= '0;
    end else begin
      flush_all  <= cmd_flush;
      flush_line <= line_wr;
      if (line_wr) flush_page <= wr_data[DATA_W-1:PAGE_SHIFT];
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFF_BASE: rd_data = {base_q, {PAGE_SHIFT{1'b0}}};
      OFF_STAT: rd_data = DATA_W'({held_q, st_q, pg_q});
      OFF_FADR: rd_data = fadr_q;
      OFF_RAW:  rd_data = DATA_W'(raw_q);
      OFF_MASK: rd_data = DATA_W'(mask_q);
      default:  rd_data = '0;
    endcase
  end

  AST_RESET_CLEARS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (base_q == '0 && !pg_q)); // R5
  AST_PAGING_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_q != $past(pg_q)) |-> ($past(pg_cnt) == CNT_ONE || $past(cmd_rst))); // R4
  AST_STALL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != $past(st_q)) |-> ($past(st_cnt) == CNT_ONE)); // R4
  AST_FLUSH_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |-> $past(cmd_flush)); // R6
  AST_FAULT_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && $past(held_q)) |-> $stable(fadr_q)); // R8
  AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bits[0] && !fault_take) |=> !raw_q[0]); // R10
endmodule

// File: tb/sim_mmu_ctl.sv
module sim_mmu_ctl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, fault_valid = 1'b0, bus_err = 1'b0;
  logic [7:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, fault_addr = '0, rd_data;
  logic irq, paging_on, stall_on, flush_all, flush_line;
  logic [19:0] flush_page;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  mmu_ctl u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .fault_valid(fault_valid), .fault_addr(fault_addr), .bus_err(bus_err),
    .irq(irq), .paging_on(paging_on), .stall_on(stall_on),
    .flush_all(flush_all), .flush_line(flush_line), .flush_page(flush_page));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic fault(input logic [31:0] a);
    fault_valid = 1'b1; fault_addr = a;
    @(posedge clk); @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    foreach (v[i]) ;
    for (int a = 0; a < 32; a += 4) begin
      rd(8'(a), v);
      chk("R1 reg", v, 0);
    end
    chk("R1 outs", {irq, paging_on, stall_on, flush_all, flush_line}, 0);
  endtask

  task automatic t_base;
    logic [31:0] v;
    wr(8'h00, 32'hABCDE123); rd(8'h00, v); chk("R2 base", v, 32'hABCDE000);
    wr(8'h00, 32'hF0000FFF); rd(8'h00, v); chk("R2 base upper", v, 32'hF0000000);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    wr(8'h08, 2);
    for (int i = 0; i < 3; i++) begin
      chk("R4 stall early", stall_on, 0);
      @(negedge clk);
    end
    chk("R4 stall early", stall_on, 0);
    @(negedge clk);
    chk("R4 stall on", stall_on, 1);
    rd(8'h04, v); chk("R4 status stall", v, 2);
    wr(8'h08, 0);
    idle(3); chk("R4 paging early", paging_on, 0);
    @(negedge clk); chk("R4 paging on", paging_on, 1);
    rd(8'h04, v); chk("R4 status both", v, 3);
  endtask

  task automatic t_badcmd;
    logic [31:0] v;
    wr(8'h08, 7); chk("R3 code7 flush", {flush_all, flush_line}, 0);
    wr(8'h08, 15); chk("R3 code15 flush", {flush_all, flush_line}, 0);
    idle(6);
    rd(8'h04, v); chk("R3 bad code status", v, 3);
    rd(8'h00, v); chk("R3 bad code base", v, 32'hF0000000);
  endtask

  task automatic t_freset;
    logic [31:0] v;
    bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
    rd(8'h14, v); chk("R9 bus err set", v, 2);
    wr(8'h08, 6);
    rd(8'h00, v); chk("R5 base zero", v, 0);
    chk("R5 paging off", paging_on, 0);
    chk("R5 stall kept", stall_on, 1);
    rd(8'h14, v); chk("R5 raw cleared", v, 0);
    wr(8'h08, 3); idle(3); chk("R3 leave stall early", stall_on, 1);
    @(negedge clk); chk("R3 leave stall", stall_on, 0);
    wr(8'h08, 0); idle(4); chk("R3 paging on", paging_on, 1);
    wr(8'h08, 1); idle(3); chk("R3 paging off early", paging_on, 1);
    @(negedge clk); chk("R3 paging off", paging_on, 0);
  endtask

  task automatic t_flush;
    wr(8'h08, 4); chk("R6 flush high", flush_all, 1);
    @(negedge clk); chk("R6 flush one cycle", flush_all, 0);
    wr(8'h10, 32'h12345ABC);
    chk("R7 line high", flush_line, 1); chk("R7 page", flush_page, 32'h12345);
    @(negedge clk); chk("R7 line one cycle", flush_line, 0);
  endtask

  task automatic t_fault;
    logic [31:0] v;
    fault(32'hDEAD0001);
    rd(8'h0C, v); chk("R8 off ignored addr", v, 0);
    rd(8'h14, v); chk("R8 off ignored raw", v, 0);
    wr(8'h08, 0); idle(4);
    fault(32'h00401234);
    rd(8'h0C, v); chk("R8 captured", v, 32'h00401234);
    rd(8'h04, v); chk("R8 held bit", v, 5);
    rd(8'h14, v); chk("R8 raw bit", v, 1);
    fault(32'h00808888);
    rd(8'h0C, v); chk("R8 held addr", v, 32'h00401234);
    wr(8'h08, 5);
    rd(8'h04, v); chk("R8 released", v, 1);
    fault(32'h00C0CCCC);
    rd(8'h0C, v); chk("R8 recapture", v, 32'h00C0CCCC);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    chk("R11 masked", irq, 0);
    wr(8'h1C, 1); chk("R11 unmasked", irq, 1);
    rd(8'h1C, v); chk("R11 mask read", v, 1);
    wr(8'h18, 1); rd(8'h14, v); chk("R10 w1c", v, 0);
    chk("R11 irq low", irq, 0);
    bus_err = 1'b1; @(negedge clk); bus_err = 1'b0;
    chk("R11 bit1 masked", irq, 0);
    wr(8'h1C, 3); chk("R11 bit1 unmasked", irq, 1);
    bus_err = 1'b1; wr(8'h18, 2); bus_err = 1'b0;
    rd(8'h14, v); chk("R10 set wins", v, 2);
    wr(8'h18, 2); rd(8'h14, v); chk("R10 cleared", v, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base();
    t_mode();
    t_badcmd();
    t_freset();
    t_flush();
    t_fault();
    t_irq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule